// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles every control transfer of a 32-bit RISC-V style core within a single combinational stage. It takes the current program counter, the two source operands, the already sign-extended immediate, a three-bit operation select, a compressed-instruction flag and the destination register index. From these it returns four results: whether the transfer is taken, the address to fetch next, the link value, and whether that link value is written back. It also raises a flag when the chosen target is not 2-byte aligned.

The six conditional branches resolve equality, signed order and unsigned order as separate results. Both jump kinds are always taken. The link value is always the address of the next instruction in sequence, which sits 2 bytes further on for a compressed instruction and 4 bytes further on otherwise. The datapath width and the way the comparator is built are parameters.

Top module: `bju_resolve`

## Requirements
- R1: The operation codes on `op_i` are 0 beq, 1 bne, 2 jal, 3 jalr, 4 blt, 5 bge, 6 bltu, 7 bgeu. For beq, `taken_o` is 1 exactly when `rs1_i == rs2_i`. For bne, it is 1 exactly when they differ.
- R2: For blt, `taken_o` is 1 when `rs1_i` is less than `rs2_i` as two's-complement numbers. For bge, it is 1 when `rs1_i` is greater than or equal to `rs2_i` in the same sense.
- R3: For bltu, `taken_o` is 1 when `rs1_i` is less than `rs2_i` as unsigned numbers. For bgeu, it is 1 when `rs1_i` is greater than or equal to `rs2_i` as unsigned numbers.
- R4: When a branch is taken, and for every jal, `next_pc_o` equals `pc_i + imm_i` modulo 2^XLEN.
- R5: For jalr, `next_pc_o` equals `rs1_i + imm_i` modulo 2^XLEN, with bit 0 forced to 0.
- R6: When a branch is not taken, `next_pc_o` equals `pc_i + 2` if `compressed_i` is 1 and `pc_i + 4` if it is 0.
- R7: `link_o` always equals `pc_i + 2` if `compressed_i` is 1 and `pc_i + 4` if it is 0. `link_we_o` is 1 only for jal or jalr with `rd_i` not equal to 0; it is 0 for every branch and whenever `rd_i` is 0.
- R8: For jal and jalr, `taken_o` is always 1.
- R9: `misalign_o` is 1 exactly when `taken_o` is 1 and bit 0 of `next_pc_o` is 1. As a result it is never 1 for jalr.
- R10: The subtractor-based comparator (CMP_STYLE 0) and the direct comparator (CMP_STYLE 1) give identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | Address of the current instruction |
| rs1_i | input | XLEN | First source operand, and the base for jalr |
| rs2_i | input | XLEN | Second source operand |
| imm_i | input | XLEN | Sign-extended immediate |
| op_i | input | 3 | Operation select, with codes as in R1 |
| compressed_i | input | 1 | 1 for a 16-bit instruction |
| rd_i | input | REG_AW | Destination register index |
| taken_o | output | 1 | Control transfer is taken |
| next_pc_o | output | XLEN | Address to fetch next |
| link_o | output | XLEN | Address of the next instruction in sequence |
| link_we_o | output | 1 | Write `link_o` to `rd_i` |
| misalign_o | output | 1 | Taken target is not 2-byte aligned |

## Verification
The assertions check several relations on every input change:
- equality excludes both orderings;
- the signed and unsigned orderings disagree only when the operand sign bits differ;
- a jalr target is always even;
- a transfer that is not taken lands on the link address;
- branches never write a link, and the misalignment flag never pairs with jalr.

Only the bench's sweeps can show the rest: the exact arithmetic of the targets, the wrap-around at the top of the address space, the correct polarity of each branch condition, and the match between the two comparator variants. The bench sweeps every operand pair and every operation at a narrow width, then applies boundary and random operands at full width.

// File: rtl/bju_pkg.sv
package bju_pkg;

   typedef enum logic [2:0] {
      OP_BEQ  = 3'd0,
      OP_BNE  = 3'd1,
      OP_JAL  = 3'd2,
      OP_JALR = 3'd3,
      OP_BLT  = 3'd4,
      OP_BGE  = 3'd5,
      OP_BLTU = 3'd6,
      OP_BGEU = 3'd7
   } bju_op_t;

   typedef struct packed {
      logic eq;
      logic lt_s;
      logic lt_u;
   } cmp_flags_t;

   function automatic logic op_is_jump(bju_op_t op);
      return (op == OP_JAL) || (op == OP_JALR);
   endfunction

endpackage

// File: rtl/bju_compare.sv
module bju_compare
   import bju_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CMP_STYLE = 0
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output cmp_flags_t      flags_o
);
   localparam int MSB = XLEN - 1;

   generate
      if (CMP_STYLE == 0) begin : g_sub
         logic [XLEN:0] diff;
         always_comb begin
            diff          = {1'b0, a_i} - {1'b0, b_i};
            flags_o.eq    = (a_i == b_i);
            flags_o.lt_u  = diff[XLEN];
            flags_o.lt_s  = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : diff[XLEN];
         end
      end else begin : g_direct
         always_comb begin
            flags_o.eq    = (a_i == b_i);
            flags_o.lt_u  = (a_i < b_i);
            flags_o.lt_s  = ($signed(a_i) < $signed(b_i));
         end
      end
   endgenerate

   always_comb begin
      p_eq_excl_r1 : assert (!(flags_o.eq && (flags_o.lt_s || flags_o.lt_u)))
         else $error("equal operands reported as ordered");
      p_sign_split_r2 : assert ((flags_o.lt_s == flags_o.lt_u) || (a_i[MSB] != b_i[MSB]))
         else $error("signed and unsigned order differ with equal sign bits");
   end

endmodule

// File: rtl/bju_target.sv
module bju_target #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] rs1_i,
   input  logic [XLEN-1:0] imm_i,
   input  logic            compressed_i,
   output logic [XLEN-1:0] seq_o,
   output logic [XLEN-1:0] pcrel_o,
   output logic [XLEN-1:0] regrel_o
);
   localparam logic [XLEN-1:0] STEP_C    = XLEN'(2);
   localparam logic [XLEN-1:0] STEP_W    = XLEN'(4);
   localparam logic [XLEN-1:0] EVEN_MASK = {{(XLEN-1){1'b1}}, 1'b0};

   logic [XLEN-1:0] reg_sum;

   always_comb begin
      seq_o    = pc_i + (compressed_i ? STEP_C : STEP_W);
      pcrel_o  = pc_i + imm_i;
      reg_sum  = rs1_i + imm_i;
      regrel_o = reg_sum & EVEN_MASK;
   end

endmodule

// File: rtl/bju_resolve.sv
module bju_resolve
   import bju_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int REG_AW    = 5,
   parameter int CMP_STYLE = 0
) (
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   rs1_i,
   input  logic [XLEN-1:0]   rs2_i,
   input  logic [XLEN-1:0]   imm_i,
   input  logic [2:0]        op_i,
   input  logic              compressed_i,
   input  logic [REG_AW-1:0] rd_i,
   output logic              taken_o,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              link_we_o,
   output logic [XLEN-1:0]   link_o,
   output logic              misalign_o
);
   generate
      if (XLEN < 4) begin : g_bad_xlen
         $error("bju_resolve: XLEN must be at least 4");
      end
      if (REG_AW < 1) begin : g_bad_aw
         $error("bju_resolve: REG_AW must be at least 1");
      end
      if ((CMP_STYLE != 0) && (CMP_STYLE != 1)) begin : g_bad_style
         $error("bju_resolve: CMP_STYLE must be 0 or 1");
      end
   endgenerate

   bju_op_t         op;
   cmp_flags_t      flags;
   logic            cond;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] pcrel;
   logic [XLEN-1:0] regrel;

   assign op = bju_op_t'(op_i);

   bju_compare #(
      .XLEN      (XLEN),
      .CMP_STYLE (CMP_STYLE)
   ) cmp_i (
      .a_i     (rs1_i),
      .b_i     (rs2_i),
      .flags_o (flags)
   );

   bju_target #(
      .XLEN (XLEN)
   ) tgt_i (
      .pc_i         (pc_i),
      .rs1_i        (rs1_i),
      .imm_i        (imm_i),
      .compressed_i (compressed_i),
      .seq_o        (seq_pc),
      .pcrel_o      (pcrel),
      .regrel_o     (regrel)
   );

   always_comb begin
      unique case (op)
         OP_BEQ:  cond = flags.eq;
         OP_BNE:  cond = !flags.eq;
         OP_BLT:  cond = flags.lt_s;
         OP_BGE:  cond = !flags.lt_s;
         OP_BLTU: cond = flags.lt_u;
         OP_BGEU: cond = !flags.lt_u;
         default: cond = 1'b1;
      endcase
   end

   always_comb begin
      taken_o   = cond;
      link_o    = seq_pc;
      link_we_o = op_is_jump(op) && (rd_i != '0);
      if (!cond)
         next_pc_o = seq_pc;
      else if (op == OP_JALR)
         next_pc_o = regrel;
      else
         next_pc_o = pcrel;
      misalign_o = taken_o && next_pc_o[0];
   end

   always_comb begin
      p_jalr_even_r5 : assert ((op != OP_JALR) || !next_pc_o[0])
         else $error("jalr target is odd");
      p_fallthru_r6 : assert (taken_o || (next_pc_o == link_o))
         else $error("not-taken next pc differs from sequential address");
      p_branch_nowr_r7 : assert (op_is_jump(op) || !link_we_o)
         else $error("branch requested a link write");
      p_link_step_r7 : assert (((link_o - pc_i) == XLEN'(2)) || ((link_o - pc_i) == XLEN'(4)))
         else $error("link is not the next sequential address");
      p_jump_taken_r8 : assert (!op_is_jump(op) || taken_o)
         else $error("jump reported as not taken");
      p_misalign_r9 : assert (!misalign_o || (taken_o && (op != OP_JALR)))
         else $error("misalign flag on a non-taken transfer or on jalr");
   end

endmodule

// File: tb/bju_resolve_tb_top.sv
module bju_resolve_tb_top;

   localparam int NW = 6;
   localparam int WW = 32;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [WW-1:0] pc, rs1, rs2, imm;
   logic [2:0]    op;
   logic          comp;
   logic [AW-1:0] rd;

   logic          tk_n, we_n, ma_n, tk_b, we_b, ma_b, tk_w, we_w, ma_w;
   logic [NW-1:0] np_n, lk_n, np_b, lk_b;
   logic [WW-1:0] np_w, lk_w;

   bju_resolve #(.XLEN(NW), .REG_AW(AW), .CMP_STYLE(0)) dut_i (
      .pc_i(pc[NW-1:0]), .rs1_i(rs1[NW-1:0]), .rs2_i(rs2[NW-1:0]), .imm_i(imm[NW-1:0]),
      .op_i(op), .compressed_i(comp), .rd_i(rd),
      .taken_o(tk_n), .next_pc_o(np_n), .link_we_o(we_n), .link_o(lk_n), .misalign_o(ma_n));

   bju_resolve #(.XLEN(NW), .REG_AW(AW), .CMP_STYLE(1)) dut_b (
      .pc_i(pc[NW-1:0]), .rs1_i(rs1[NW-1:0]), .rs2_i(rs2[NW-1:0]), .imm_i(imm[NW-1:0]),
      .op_i(op), .compressed_i(comp), .rd_i(rd),
      .taken_o(tk_b), .next_pc_o(np_b), .link_we_o(we_b), .link_o(lk_b), .misalign_o(ma_b));

   bju_resolve #(.XLEN(WW), .REG_AW(AW), .CMP_STYLE(1)) dut_w (
      .pc_i(pc), .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm),
      .op_i(op), .compressed_i(comp), .rd_i(rd),
      .taken_o(tk_w), .next_pc_o(np_w), .link_we_o(we_w), .link_o(lk_w), .misalign_o(ma_w));

   function automatic string tk_req(logic [2:0] o);
      case (o)
         3'd0, 3'd1: return "R1";
         3'd4, 3'd5: return "R2";
         3'd6, 3'd7: return "R3";
         default:    return "R8";
      endcase
   endfunction

   task automatic cmp(string req, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s op=%0d rs1=%h rs2=%h pc=%h imm=%h c=%0b: actual %h expected %h",
                  req, what, op, rs1, rs2, pc, imm, comp, act, exp);
      end
   endtask

   // Reference model at width w
   task automatic check_w(int w, logic t_a, logic [WW-1:0] np_a, logic [WW-1:0] lk_a,
                          logic we_a, logic ma_a);
      logic [WW-1:0] m, sb, a, b, p, im, seq, npc;
      logic eq, lts, ltu, t;
      m   = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 32'd1);
      sb  = 32'd1 << (w - 1);
      a   = rs1 & m;  b = rs2 & m;  p = pc & m;  im = imm & m;
      eq  = (a == b);
      ltu = (a < b);
      lts = ((a ^ sb) < (b ^ sb));
      case (op)
         3'd0: t = eq;
         3'd1: t = !eq;
         3'd4: t = lts;
         3'd5: t = !lts;
         3'd6: t = ltu;
         3'd7: t = !ltu;
         default: t = 1'b1;
      endcase
      seq = (p + (comp ? 32'd2 : 32'd4)) & m;
      if (!t)            npc = seq;
      else if (op == 3)  npc = (a + im) & m & ~32'd1;
      else               npc = (p + im) & m;
      cmp(tk_req(op), "taken", {31'd0, t_a}, {31'd0, t});
      cmp(!t ? "R6" : (op == 3) ? "R5" : "R4", "next_pc", np_a, npc);
      cmp("R7", "link", lk_a, seq);
      cmp("R7", "link_we", {31'd0, we_a}, {31'd0, ((op == 2) || (op == 3)) && (rd != 0)});
      cmp("R9", "misalign", {31'd0, ma_a}, {31'd0, t && npc[0]});
   endtask

   task automatic apply(logic [2:0] o, logic [WW-1:0] p, logic [WW-1:0] a, logic [WW-1:0] b,
                        logic [WW-1:0] im, logic c, logic [AW-1:0] r);
      @(negedge clk);
      op = o; pc = p; rs1 = a; rs2 = b; imm = im; comp = c; rd = r;
      #5;
      check_w(NW, tk_n, {26'd0, np_n}, {26'd0, lk_n}, we_n, ma_n);
      check_w(NW, tk_b, {26'd0, np_b}, {26'd0, lk_b}, we_b, ma_b);
      check_w(WW, tk_w, np_w, lk_w, we_w, ma_w);
      cmp("R10", "variant match",
          {12'd0, tk_n, np_n, lk_n, we_n, ma_n}, {12'd0, tk_b, np_b, lk_b, we_b, ma_b});
   endtask

   localparam logic [31:0] EDGE [5] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff};

   initial begin
      op = 0; pc = 0; rs1 = 0; rs2 = 0; imm = 0; comp = 0; rd = 0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // initial all-zero state: beq of equal zeros is taken to address 0 (R1, R4)
      #5;
      cmp("R1", "idle taken", {31'd0, tk_w}, 32'd1);
      cmp("R4", "idle next_pc", np_w, 32'd0);
      // exhaustive narrow sweep
      for (int a = 0; a < 64; a++)
         for (int b = 0; b < 64; b++)
            for (int o = 0; o < 8; o++)
               apply(3'(o), 32'(a * 5 + b * 7 + o), 32'(a), 32'(b), 32'((b * 3) ^ a ^ (o << 1)),
                     1'(a ^ (b >> 1)), AW'((a + b + o) % 4));
      // wide boundary operands, including wrap-around of targets
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 5; j++)
            for (int o = 0; o < 8; o++)
               apply(3'(o), EDGE[(i + o) % 5], EDGE[i], EDGE[j], EDGE[(j + 2) % 5],
                     1'(o & 1), AW'(i));
      // wide random operands
      for (int k = 0; k < 3000; k++)
         apply(3'($urandom), $urandom, $urandom, ($urandom % 4 == 0) ? rs1 : $urandom,
               $urandom, 1'($urandom), AW'($urandom));
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule